// File: doc/BRIEF.md
# Integer Execute Unit with Selectable Carry and Condition Field

This block is the arithmetic and logic stage of a 64-bit integer pipeline. A decoder hands it validated register read values, an optional immediate and a small set of control fields. The unit builds two operands, can complement the first one, adds a carry-in picked from zero, one or a saved carry bit, and performs one of four operations: add, AND, OR or multiply keeping the low 64 bits. Subtraction and negation need no opcode of their own: complement operand A and add with a carry-in of one. Multi-word arithmetic chains through the saved carry.

Each accepted operation can load the saved carry bit and a 3-bit condition field from its result. It can also send a 64-bit write-back value, with an enable, to the register file one clock later. The block keeps no state machine. Its only state is the carry bit, the condition field and the write-back register. All three are cleared by reset and change only on a clock edge that carries a valid operation strobe.

Top module: `alu_carry_cr`

## Requirements
- R1: Operand A is rd1_data when rd1_valid is 1, otherwise rd3_data when rd3_valid is 1, otherwise zero.
- R2: Operand B is imm_data when imm_valid is 1, otherwise rd2_data when rd2_valid is 1, otherwise zero.
- R3: When invert_a is 1, operand A is replaced by its 64-bit bitwise complement before the operation.
- R4: cin_sel picks the carry-in: 2'b00 gives zero, 2'b01 gives one, 2'b10 gives the saved carry as it stood before the clock edge, and 2'b11 gives zero.
- R5: opcode 2'b00 gives A+B+carry-in, 2'b01 gives A AND B, 2'b10 gives A OR B, and 2'b11 gives the low 64 bits of A×B. Carry-in affects only the add.
- R6: When op_valid and carry_wr are both 1 at a clock edge, carry_flag becomes bit 64 of the unbounded result. That bit is 0 for AND, OR and multiply. Otherwise carry_flag holds.
- R7: When op_valid and record are both 1 at a clock edge, cond_field becomes 3'b001 if the unbounded result is zero, 3'b100 if bit 63 or bit 64 of that result is 1, and 3'b010 otherwise. Otherwise cond_field holds.
- R8: After a clock edge where op_valid and wr_valid are both 1, wb_en is 1 and wb_data is the result truncated to 64 bits. After any other edge wb_en is 0 and wb_data holds.
- R9: While rst_n is 0, carry_flag, cond_field, wb_en and wb_data are all zero.
- R10: An operation in the cycle right after a carry update sees the updated carry when it selects the saved carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Strobe: an operation is present this cycle |
| opcode | input | 2 | Operation select (R5 encoding) |
| rd1_valid | input | 1 | Read port 1 value is valid |
| rd1_data | input | 64 | Read port 1 value |
| rd2_valid | input | 1 | Read port 2 value is valid |
| rd2_data | input | 64 | Read port 2 value |
| rd3_valid | input | 1 | Read port 3 value is valid |
| rd3_data | input | 64 | Read port 3 value |
| imm_valid | input | 1 | Immediate is valid |
| imm_data | input | 64 | Immediate value |
| invert_a | input | 1 | Complement operand A |
| cin_sel | input | 2 | Carry-in select (R4 encoding) |
| carry_wr | input | 1 | Load the saved carry from this result |
| record | input | 1 | Load the condition field from this result |
| wr_valid | input | 1 | Result is to be written back |
| wb_en | output | 1 | Write-back enable, registered |
| wb_data | output | 64 | Write-back value, registered |
| carry_flag | output | 1 | Saved carry bit |
| cond_field | output | 3 | Condition field: 100 negative/overflowed, 010 positive, 001 zero |

## Verification
Two things can fall in the same cycle. An add can read the saved carry as its carry-in while the same operation loads a new carry from its own sum. The bench provokes this with chained extended adds using cin_sel=2'b10 and carry_wr=1 on consecutive cycles, and with an all-ones plus one that wraps to zero while setting the carry. A behavioural model computes each result in 128-bit arithmetic from the carry held before the edge. It is compared against carry_flag, cond_field, wb_en and wb_data after every clock, so reading a freshly written carry too early or too late shows up as a mismatch.

// File: rtl/alu_cr_pkg.sv
package alu_cr_pkg;
    typedef enum logic [1:0] {
        OPC_ADD   = 2'b00,
        OPC_AND   = 2'b01,
        OPC_OR    = 2'b10,
        OPC_MULLO = 2'b11
    } alu_opc_e;

    typedef enum logic [1:0] {
        CIN_ZERO  = 2'b00,
        CIN_ONE   = 2'b01,
        CIN_SAVED = 2'b10,
        CIN_RSVD  = 2'b11
    } cin_sel_e;

    localparam logic [2:0] COND_NEG  = 3'b100;
    localparam logic [2:0] COND_POS  = 3'b010;
    localparam logic [2:0] COND_ZERO = 3'b001;
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
    parameter int XLEN = 64
) (
    input  logic            rd1_valid,
    input  logic [XLEN-1:0] rd1_data,
    input  logic            rd2_valid,
    input  logic [XLEN-1:0] rd2_data,
    input  logic            rd3_valid,
    input  logic [XLEN-1:0] rd3_data,
    input  logic            imm_valid,
    input  logic [XLEN-1:0] imm_data,
    input  logic            invert_a,
    output logic [XLEN-1:0] opa,
    output logic [XLEN-1:0] opb
);
    logic [XLEN-1:0] a_raw;

    // R1: port 1 wins over port 3, zero when neither is valid
    always_comb begin
        if (rd1_valid)      a_raw = rd1_data;
        else if (rd3_valid) a_raw = rd3_data;
        else                a_raw = '0;
    end

    // R3: optional complement of A
    assign opa = invert_a ? ~a_raw : a_raw;

    // R2: immediate overrides port 2
    always_comb begin
        if (imm_valid)      opb = imm_data;
        else if (rd2_valid) opb = rd2_data;
        else                opb = '0;
    end
endmodule

// File: rtl/alu_compute.sv
module alu_compute
    import alu_cr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [1:0]      opcode,
    input  logic [1:0]      cin_sel,
    input  logic            saved_carry,
    output logic [XLEN:0]   res_ext
);
    localparam int EXT = XLEN + 1;

    logic            cin;
    logic [EXT-1:0]  sum_ext;
    logic [XLEN-1:0] prod_lo;

    // R4: carry-in source
    always_comb begin
        unique case (cin_sel)
            CIN_ONE:   cin = 1'b1;
            CIN_SAVED: cin = saved_carry;
            default:   cin = 1'b0;
        endcase
    end

    assign sum_ext = {1'b0, opa} + {1'b0, opb} + {{XLEN{1'b0}}, cin};
    assign prod_lo = opa * opb;

    // R5: operation select; non-add results never reach bit XLEN
    always_comb begin
        unique case (opcode)
            OPC_ADD:   res_ext = sum_ext;
            OPC_AND:   res_ext = {1'b0, opa & opb};
            OPC_OR:    res_ext = {1'b0, opa | opb};
            default:   res_ext = {1'b0, prod_lo};
        endcase
    end
endmodule

// File: rtl/alu_flag_regs.sv
module alu_flag_regs
    import alu_cr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_carry,
    input  logic          upd_cond,
    input  logic [XLEN:0] res_ext,
    output logic          carry_q,
    output logic [2:0]    cond_q
);
    logic [2:0] cond_next;

    // R7: zero first, then sign/overflow bits, else positive
    always_comb begin
        if (res_ext == '0)              cond_next = COND_ZERO;
        else if (|res_ext[XLEN:XLEN-1]) cond_next = COND_NEG;
        else                            cond_next = COND_POS;
    end

    // R6 R7 R9
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            cond_q  <= 3'b000;
        end else begin
            if (upd_carry) carry_q <= res_ext[XLEN];
            if (upd_cond)  cond_q  <= cond_next;
        end
    end

    // R6
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_carry |=> $stable(carry_q));

    // R7
    cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_cond |=> $stable(cond_q));

    // R7
    cond_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cond_q));
endmodule

// File: rtl/alu_carry_cr.sv
module alu_carry_cr
    import alu_cr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [1:0]      opcode,
    input  logic            rd1_valid,
    input  logic [XLEN-1:0] rd1_data,
    input  logic            rd2_valid,
    input  logic [XLEN-1:0] rd2_data,
    input  logic            rd3_valid,
    input  logic [XLEN-1:0] rd3_data,
    input  logic            imm_valid,
    input  logic [XLEN-1:0] imm_data,
    input  logic            invert_a,
    input  logic [1:0]      cin_sel,
    input  logic            carry_wr,
    input  logic            record,
    input  logic            wr_valid,
    output logic            wb_en,
    output logic [XLEN-1:0] wb_data,
    output logic            carry_flag,
    output logic [2:0]      cond_field
);
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic [XLEN:0]   res_ext;

    alu_operand_sel #(.XLEN(XLEN)) u_opsel (
        .rd1_valid (rd1_valid),
        .rd1_data  (rd1_data),
        .rd2_valid (rd2_valid),
        .rd2_data  (rd2_data),
        .rd3_valid (rd3_valid),
        .rd3_data  (rd3_data),
        .imm_valid (imm_valid),
        .imm_data  (imm_data),
        .invert_a  (invert_a),
        .opa       (opa),
        .opb       (opb)
    );

    alu_compute #(.XLEN(XLEN)) u_comp (
        .opa         (opa),
        .opb         (opb),
        .opcode      (opcode),
        .cin_sel     (cin_sel),
        .saved_carry (carry_flag),
        .res_ext     (res_ext)
    );

    alu_flag_regs #(.XLEN(XLEN)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_carry (op_valid & carry_wr),
        .upd_cond  (op_valid & record),
        .res_ext   (res_ext),
        .carry_q   (carry_flag),
        .cond_q    (cond_field)
    );

    // R8 R9: registered write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en   <= 1'b0;
            wb_data <= '0;
        end else begin
            wb_en <= op_valid & wr_valid;
            if (op_valid & wr_valid) wb_data <= res_ext[XLEN-1:0];
        end
    end

    // R1
    opa_port1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_valid && !invert_a) |-> (opa == rd1_data));

    // R5
    and_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_AND) |-> ((res_ext[XLEN-1:0] & ~opa) == '0));

    // R5
    or_superset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_OR) |-> ((res_ext[XLEN-1:0] & opb) == opb));

    // R8
    wb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && wr_valid) |=> (!wb_en && $stable(wb_data)));
endmodule

// File: tb/alu_carry_cr_tb.sv
module alu_carry_cr_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [1:0]  opcode;
    logic        rd1_valid, rd2_valid, rd3_valid, imm_valid;
    logic [63:0] rd1_data, rd2_data, rd3_data, imm_data;
    logic        invert_a;
    logic [1:0]  cin_sel;
    logic        carry_wr, record, wr_valid;
    logic        wb_en;
    logic [63:0] wb_data;
    logic        carry_flag;
    logic [2:0]  cond_field;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // behavioural model state
    bit          m_carry;
    bit [2:0]    m_cond;
    bit          m_wben;
    bit [63:0]   m_wbdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_carry_cr u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .rd1_valid(rd1_valid), .rd1_data(rd1_data),
        .rd2_valid(rd2_valid), .rd2_data(rd2_data),
        .rd3_valid(rd3_valid), .rd3_data(rd3_data),
        .imm_valid(imm_valid), .imm_data(imm_data),
        .invert_a(invert_a), .cin_sel(cin_sel), .carry_wr(carry_wr),
        .record(record), .wr_valid(wr_valid),
        .wb_en(wb_en), .wb_data(wb_data),
        .carry_flag(carry_flag), .cond_field(cond_field)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "carry_flag", {63'd0, carry_flag}, {63'd0, m_carry});
        chk(tag, "cond_field", {61'd0, cond_field}, {61'd0, m_cond});
        chk(tag, "wb_en", {63'd0, wb_en}, {63'd0, m_wben});
        chk(tag, "wb_data", wb_data, m_wbdata);
    endtask

    task automatic idle_inputs();
        op_valid = 0; opcode = 2'b00;
        rd1_valid = 0; rd2_valid = 0; rd3_valid = 0; imm_valid = 0;
        rd1_data = '0; rd2_data = '0; rd3_data = '0; imm_data = '0;
        invert_a = 0; cin_sel = 2'b00; carry_wr = 0; record = 0; wr_valid = 0;
    endtask

    // one clock: model evaluates inputs with pre-edge state, then compare
    task automatic cycle(input string tag);
        bit [127:0] a, b, full;
        bit         ci;
        if (rd1_valid)      a = {64'd0, rd1_data};
        else if (rd3_valid) a = {64'd0, rd3_data};
        else                a = 0;
        if (invert_a) a = {64'd0, ~a[63:0]};
        if (imm_valid)      b = {64'd0, imm_data};
        else if (rd2_valid) b = {64'd0, rd2_data};
        else                b = 0;
        case (cin_sel)
            2'b01:   ci = 1;
            2'b10:   ci = m_carry;
            default: ci = 0;
        endcase
        case (opcode)
            2'b00:   full = a + b + {127'd0, ci};
            2'b01:   full = a & b;
            2'b10:   full = a | b;
            default: full = (a * b) & {64'd0, {64{1'b1}}};
        endcase
        @(posedge clk);
        #1;
        if (op_valid && carry_wr) m_carry = full[64];
        if (op_valid && record) begin
            if (full == 0)              m_cond = 3'b001;
            else if (full[127:63] != 0) m_cond = 3'b100;
            else                        m_cond = 3'b010;
        end
        m_wben = op_valid && wr_valid;
        if (m_wben) m_wbdata = full[63:0];
        compare_all(tag);
        @(negedge clk);
    endtask

    task automatic op(input logic [1:0] opc, input logic [1:0] cs,
                      input logic inv, input logic cw, input logic rc,
                      input logic wv);
        op_valid = 1; opcode = opc; cin_sel = cs; invert_a = inv;
        carry_wr = cw; record = rc; wr_valid = wv;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        m_carry = 0; m_cond = 0; m_wben = 0; m_wbdata = 0;
        // R9: drive activity during reset, outputs must stay zero
        op(2'b00, 2'b01, 1, 1, 1, 1);
        rd1_valid = 1; rd1_data = 64'h5;
        @(negedge clk);
        @(posedge clk); #1;
        compare_all("R9");
        @(negedge clk);
        rst_n = 1;
        idle_inputs();

        // R1 R2 R5 R8: add from port1 + port2
        op(2'b00, 2'b00, 0, 0, 1, 1);
        rd1_valid = 1; rd1_data = 64'h1234; rd2_valid = 1; rd2_data = 64'h5678;
        cycle("R1_R5_R8_add");
        // R2: immediate overrides port 2
        imm_valid = 1; imm_data = 64'h100;
        cycle("R2_imm");
        // R1: port 3 when port 1 invalid
        rd1_valid = 0; rd3_valid = 1; rd3_data = 64'h7; imm_valid = 0;
        cycle("R1_port3");
        // R1 R2: nothing valid -> 0 + 0, cond zero
        idle_inputs(); op(2'b00, 2'b00, 0, 0, 1, 1);
        cycle("R1_R2_none_R7_zero");
        // R5: AND and OR
        idle_inputs(); op(2'b01, 2'b01, 0, 1, 1, 1);
        rd1_valid = 1; rd1_data = 64'hF0F0_0000_FFFF_1234;
        rd2_valid = 1; rd2_data = 64'hFF00_FF00_0F0F_00FF;
        cycle("R5_and_R6_zero");
        opcode = 2'b10;
        cycle("R5_or_R7_neg");
        // R5: multiply low
        opcode = 2'b11; rd1_data = 64'd3; rd2_data = 64'd2;
        cycle("R5_mul");
        rd1_data = 64'hFFFF_FFFF_FFFF_FFFF;
        cycle("R5_mul_wrap");
        // R3 R4: subtract B - A via invert + one
        idle_inputs(); op(2'b00, 2'b01, 1, 1, 1, 1);
        rd1_valid = 1; rd1_data = 64'h1234; rd2_valid = 1; rd2_data = 64'h5678;
        cycle("R3_R4_sub");
        // R3: negate (B=0)
        rd2_valid = 0;
        cycle("R3_neg");
        // R6 R7: all ones + 1 wraps to zero with carry, cond negative
        idle_inputs(); op(2'b00, 2'b01, 0, 1, 1, 1);
        rd1_valid = 1; rd1_data = 64'hFFFF_FFFF_FFFF_FFFF;
        cycle("R6_R7_wrap");
        // R4 R10: saved carry read and rewritten in same cycle, chained
        idle_inputs(); op(2'b00, 2'b10, 0, 1, 1, 1);
        rd1_valid = 1; rd1_data = 64'hFFFF_FFFF_FFFF_FFFF;
        cycle("R4_R10_chain1");
        rd1_data = 64'h10;
        cycle("R4_R10_chain2");
        // R4: reserved select gives zero carry-in
        idle_inputs(); op(2'b00, 2'b01, 0, 1, 0, 0);
        rd1_valid = 1; rd1_data = 64'hFFFF_FFFF_FFFF_FFFF;
        cycle("R6_set");
        op(2'b00, 2'b11, 0, 0, 0, 1);
        rd1_data = 64'h40;
        cycle("R4_reserved");
        // R6 R7 R8: no strobe -> nothing changes, wb_en low
        op(2'b00, 2'b01, 0, 1, 1, 1); op_valid = 0;
        cycle("R6_R7_R8_nostrobe");
        // R8: strobe without wr_valid
        op(2'b10, 2'b00, 0, 0, 1, 0);
        rd1_data = 64'h1; rd2_valid = 1; rd2_data = 64'h2;
        cycle("R8_no_write_R7_pos");
        // R6: carry_wr clear holds carry
        op(2'b01, 2'b00, 0, 0, 0, 1);
        cycle("R6_hold");
        // R7: positive result
        idle_inputs(); op(2'b00, 2'b00, 0, 0, 1, 1);
        imm_valid = 1; imm_data = 64'h2A;
        cycle("R7_pos");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule